// File: doc/BRIEF.md
# Paged SPI Register Target

This block is the device end of a serial register link. An SPI master selects it with a low chip select and sends a command byte. Bit 7 of that byte picks the direction and its lower seven bits name an offset within the current page. The page is a 9-bit register inside the block, and the master sets it over the same serial link by writing to a reserved offset. Page and offset together form a 16-bit address into a local register file. The register file is also open to the surrounding logic through a simple parallel port, which can preload values and read results back.

The block runs on a system clock that is much faster than SCLK. Chip select, SCLK and MOSI pass through a synchronizer, and all edge detection is done in the system clock domain. One build-time parameter selects the page encoding. In the wide format the page offset takes a two-byte little-endian word and keeps bits 15:7 of it. In the narrow format it takes a single byte that becomes the page number.

Top module: `paged_spi_target`

## Requirements
- R1: The first byte after chip select falls is a command: bit 7 = 1 reads and bit 7 = 0 writes, and bits 6:0 are the offset. Bytes sent on MOSI during a read never change the register file.
- R2: The full address is {page[8:0], offset[6:0]}. The register file entry used is that address modulo RF_DEPTH. With the default depth of 256 the entry is {page[0], offset}.
- R3: On a write to any offset other than the page offset, the first data byte is stored at the addressed entry. The parallel port then returns that byte.
- R4: With FMT = wide, a write to offset 0x7C takes two data bytes, low byte first. The page becomes bits 15:7 of that word, which are {second byte, bit 7 of the first byte}, and the register file is left unchanged.
- R5: With FMT = narrow, a write to offset 0x7F takes one data byte, and that byte becomes the page. The register file is left unchanged. Offset 0x7C is then an ordinary register.
- R6: In mode 0, MISO changes only after SCLK falling edges. It is low during the command byte. During the next byte it carries the addressed value MSB first, and it is low after that.
- R7: After reset the page is zero and MISO is low.
- R8: The bit counter restarts whenever chip select is high. A transaction that ends before a data byte (or both bytes of a wide page word) is complete changes neither the page nor the register file.
- R9: Bytes sent after the data byte of a write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rf_addr | input | RF_AW | Parallel port register index |
| rf_we | input | 1 | Parallel port write enable |
| rf_wdata | input | 8 | Parallel port write data |
| rf_rdata | output | 8 | Parallel port read data, combinational from rf_addr |

## Verification
Most internal faults in this block show up as a wrong register index, because the page is only ever visible through the entries it selects. A page register that is stale, shifted or wrongly merged therefore surfaces on the next addressed read or write, one transaction after the faulty page update. Sweeps over several pages and spread-out offsets compare every SPI read and every parallel-port readback against a model array. A bit counter or phase that drifts shows up within the same transaction, as a misaligned MISO byte or as an entry that was written when it should not have been.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 7;
    localparam int PAGE_W = 9;
    localparam int ADDR_W = PAGE_W + OFF_W;

    typedef enum logic {
        PG_FMT_WIDE   = 1'b0,
        PG_FMT_NARROW = 1'b1
    } page_fmt_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_HIGH,
        PH_SKIP
    } phase_e;

    function automatic logic [OFF_W-1:0] page_offset(page_fmt_e f);
        return (f == PG_FMT_WIDE) ? 7'h7C : 7'h7F;
    endfunction

    typedef struct packed {
        logic              sclk_prev;
        logic [2:0]        bit_cnt;
        logic [6:0]        sh_in;
        phase_e            phase;
        logic              is_read;
        logic [OFF_W-1:0]  offset;
        logic              lo_msb;
        logic [PAGE_W-1:0] page;
        logic [BYTE_W-1:0] tx_sh;
        logic              miso;
    } core_st_t;

endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pst_regfile.sv
module pst_regfile #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int FW    = 16
) (
    input  logic          clk,
    input  logic          spi_we,
    input  logic [FW-1:0] spi_waddr,
    input  logic [7:0]    spi_wdata,
    input  logic [FW-1:0] spi_raddr,
    output logic [7:0]    spi_rdata,
    input  logic [AW-1:0] host_addr,
    input  logic          host_we,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata
);
    localparam logic [FW-1:0] DEPTH_W = FW'(DEPTH);

    logic [7:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] wrap(logic [FW-1:0] a);
        return AW'(a % DEPTH_W);
    endfunction

    // The serial side wins a same-cycle collision with the parallel port.
    always_ff @(posedge clk) begin
        if (spi_we)       mem_q[wrap(spi_waddr)] <= spi_wdata;
        else if (host_we) mem_q[host_addr]       <= host_wdata;
    end

    assign spi_rdata  = mem_q[wrap(spi_raddr)];
    assign host_rdata = mem_q[host_addr];
endmodule

// File: rtl/pst_core.sv
module pst_core
    import pst_pkg::*;
#(
    parameter page_fmt_e FMT = PG_FMT_WIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              miso,
    output logic [PAGE_W-1:0] page_out,
    output logic              page_wr,
    output logic              byte_evt,
    output logic              fall_evt,
    output logic              cs_idle,
    output logic [2:0]        bit_pos
);
    localparam logic [OFF_W-1:0] PG_OFF = page_offset(FMT);

    core_st_t st_d, st_q;
    logic       rise, fall;
    logic [7:0] rx_byte;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        wr_addr  = {st_q.page, st_q.offset};
        wr_data  = '0;
        page_wr  = 1'b0;
        byte_evt = 1'b0;
        rise     = sclk_s & ~st_q.sclk_prev;
        fall     = ~sclk_s & st_q.sclk_prev;
        rx_byte  = {st_q.sh_in, mosi_s};
        rd_addr  = {st_q.page, rx_byte[6:0]};

        st_d.sclk_prev = sclk_s;

        if (cs_n_s) begin
            st_d.bit_cnt = '0;
            st_d.phase   = PH_CMD;
            st_d.tx_sh   = '0;
            st_d.miso    = 1'b0;
        end else begin
            if (rise) begin
                st_d.sh_in   = {st_q.sh_in[5:0], mosi_s};
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    byte_evt = 1'b1;
                    unique case (st_q.phase)
                        PH_CMD: begin
                            st_d.is_read = rx_byte[7];
                            st_d.offset  = rx_byte[6:0];
                            st_d.phase   = PH_DATA;
                            if (rx_byte[7]) st_d.tx_sh = rd_data;
                        end
                        PH_DATA: begin
                            st_d.phase = PH_SKIP;
                            if (!st_q.is_read) begin
                                if (st_q.offset == PG_OFF) begin
                                    if (FMT == PG_FMT_NARROW) begin
                                        st_d.page = {1'b0, rx_byte};
                                        page_wr   = 1'b1;
                                    end else begin
                                        st_d.lo_msb = rx_byte[7];
                                        st_d.phase  = PH_HIGH;
                                    end
                                end else begin
                                    wr_en   = 1'b1;
                                    wr_data = rx_byte;
                                end
                            end
                        end
                        PH_HIGH: begin
                            st_d.page  = {rx_byte, st_q.lo_msb};
                            page_wr    = 1'b1;
                            st_d.phase = PH_SKIP;
                        end
                        PH_SKIP: ;
                    endcase
                end
            end
            if (fall) begin
                st_d.miso  = st_q.tx_sh[7];
                st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk_prev: 1'b0, bit_cnt: '0, sh_in: '0, phase: PH_CMD,
                      is_read: 1'b0, offset: '0, lo_msb: 1'b0, page: '0,
                      tx_sh: '0, miso: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign miso     = st_q.miso;
    assign page_out = st_q.page;
    assign fall_evt = fall & ~cs_n_s;
    assign cs_idle  = cs_n_s;
    assign bit_pos  = st_q.bit_cnt;
endmodule

// File: rtl/paged_spi_target.sv
module paged_spi_target
    import pst_pkg::*;
#(
    parameter page_fmt_e FMT         = PG_FMT_WIDE,
    parameter int        RF_DEPTH    = 256,
    parameter int        RF_AW       = $clog2(RF_DEPTH),
    parameter int        SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic [RF_AW-1:0] rf_addr,
    input  logic             rf_we,
    input  logic [7:0]       rf_wdata,
    output logic [7:0]       rf_rdata
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        rd_data, wr_data;
    logic              spi_wr, page_wr, byte_evt, fall_evt, cs_idle, miso_q;
    logic [PAGE_W-1:0] page_cur;
    logic [2:0]        bit_pos;

    pst_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sclk, spi_mosi}),
        .dout(pins_s)
    );

    pst_core #(.FMT(FMT)) u_core (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[1]), .cs_n_s(pins_s[2]), .mosi_s(pins_s[0]),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(spi_wr), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(miso_q), .page_out(page_cur), .page_wr(page_wr),
        .byte_evt(byte_evt), .fall_evt(fall_evt), .cs_idle(cs_idle),
        .bit_pos(bit_pos)
    );

    pst_regfile #(.DEPTH(RF_DEPTH), .AW(RF_AW), .FW(ADDR_W)) u_rf (
        .clk(clk),
        .spi_we(spi_wr), .spi_waddr(wr_addr), .spi_wdata(wr_data),
        .spi_raddr(rd_addr), .spi_rdata(rd_data),
        .host_addr(rf_addr), .host_we(rf_we), .host_wdata(rf_wdata),
        .host_rdata(rf_rdata)
    );

    assign spi_miso = miso_q;
endmodule

module pst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_idle,
    input logic       fall_evt,
    input logic       byte_evt,
    input logic       page_wr,
    input logic       spi_wr,
    input logic [8:0] page_cur,
    input logic       miso,
    input logic [2:0] bit_pos
);
    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_cur) |-> $past(page_wr));
    // R3
    wr_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_wr |-> byte_evt);
    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (bit_pos == 3'd0));
    // R6
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_evt && !cs_idle) |=> $stable(miso));
    // R5
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({page_wr, spi_wr}));
endmodule

bind paged_spi_target pst_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .fall_evt(fall_evt),
    .byte_evt(byte_evt), .page_wr(page_wr), .spi_wr(spi_wr),
    .page_cur(page_cur), .miso(spi_miso), .bit_pos(bit_pos)
);

// File: tb/paged_spi_target_test.sv
module paged_spi_target_test;
    import pst_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_a = 1'b1, cs_b = 1'b1;
    logic miso_a, miso_b;
    logic [7:0] addr_a = '0, addr_b = '0, wd_a = '0, wd_b = '0;
    logic we_a = 1'b0, we_b = 1'b0;
    logic [7:0] rd_a, rd_b;
    logic [7:0] mem_a [256];
    logic [7:0] mem_b [256];
    int compared = 0, mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    paged_spi_target #(.FMT(PG_FMT_WIDE)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_a),
        .spi_mosi(mosi), .spi_miso(miso_a), .rf_addr(addr_a), .rf_we(we_a),
        .rf_wdata(wd_a), .rf_rdata(rd_a));

    paged_spi_target #(.FMT(PG_FMT_NARROW)) uut_b (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_b),
        .spi_mosi(mosi), .spi_miso(miso_b), .rf_addr(addr_b), .rf_we(we_b),
        .rf_wdata(wd_b), .rf_rdata(rd_b));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cs_set(input int s, input logic v);
        if (s == 0) cs_a = v; else cs_b = v;
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input int s, input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            repeat (8) @(negedge clk);
            rx[i] = (s == 0) ? miso_a : miso_b;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_write(input int s, input logic [6:0] off, input logic [7:0] dat);
        logic [7:0] junk;
        cs_set(s, 1'b0);
        xfer(s, {1'b0, off}, 8, junk);
        xfer(s, dat, 8, junk);
        cs_set(s, 1'b1);
    endtask

    task automatic spi_read(input int s, input logic [6:0] off, output logic [7:0] first,
                            output logic [7:0] dat, output logic [7:0] trail);
        cs_set(s, 1'b0);
        xfer(s, {1'b1, off}, 8, first);
        xfer(s, 8'hA5, 8, dat);
        xfer(s, 8'h5A, 8, trail);
        cs_set(s, 1'b1);
    endtask

    task automatic page_wide(input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] junk;
        cs_set(0, 1'b0);
        xfer(0, 8'h7C, 8, junk);
        xfer(0, lo, 8, junk);
        xfer(0, hi, 8, junk);
        cs_set(0, 1'b1);
    endtask

    task automatic peek(input int s, input logic [7:0] idx, output logic [7:0] v);
        if (s == 0) addr_a = idx; else addr_b = idx;
        #1;
        v = (s == 0) ? rd_a : rd_b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] f, d, t, v;
        logic [8:0] pg_a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R7: MISO low after reset
        chk("R7 miso_a reset", {15'd0, miso_a}, 16'd0);
        chk("R7 miso_b reset", {15'd0, miso_b}, 16'd0);

        for (int i = 0; i < 256; i++) begin
            mem_a[i] = 8'((i * 37 + 11) & 255);
            mem_b[i] = mem_a[i] ^ 8'h5A;
            addr_a = 8'(i); addr_b = 8'(i);
            wd_a = mem_a[i]; wd_b = mem_b[i];
            we_a = 1'b1; we_b = 1'b1;
            @(negedge clk);
        end
        we_a = 1'b0; we_b = 1'b0;

        // R7: page is zero after reset, so offset 0x10 maps to entry 0x10
        spi_read(0, 7'h10, f, d, t);
        chk("R7 wide page zero", {8'd0, d}, {8'd0, mem_a[8'h10]});
        spi_read(1, 7'h10, f, d, t);
        chk("R7 narrow page zero", {8'd0, d}, {8'd0, mem_b[8'h10]});

        // R1 R2 R3 R5 R6: narrow format sweep over pages and offsets
        for (int pg = 0; pg < 6; pg++) begin
            logic [7:0] pval;
            pval = (pg < 4) ? 8'(pg) : ((pg == 4) ? 8'hFE : 8'hFF);
            spi_write(1, 7'h7F, pval);
            peek(1, {pval[0], 7'h7F}, v);
            chk("R5 page write leaves rf", {8'd0, v}, {8'd0, mem_b[{pval[0], 7'h7F}]});
            for (int k = 0; k < 8; k++) begin
                logic [6:0] off;
                logic [7:0] idx, nv;
                off = 7'(k * 17);
                idx = {pval[0], off};
                spi_read(1, off, f, d, t);
                chk("R2 narrow read", {8'd0, d}, {8'd0, mem_b[idx]});
                chk("R6 miso low in command", {8'd0, f}, 16'd0);
                chk("R6 miso low after data", {8'd0, t}, 16'd0);
                peek(1, idx, v);
                chk("R1 read leaves rf", {8'd0, v}, {8'd0, mem_b[idx]});
                nv = 8'((pg * 16 + k) ^ 8'hC3);
                spi_write(1, off, nv);
                mem_b[idx] = nv;
                peek(1, idx, v);
                chk("R3 narrow write", {8'd0, v}, {8'd0, nv});
            end
        end
        // R5: offset 0x7C is ordinary in narrow format (page now 0xFF)
        spi_write(1, 7'h7C, 8'h3D);
        mem_b[8'hFC] = 8'h3D;
        peek(1, 8'hFC, v);
        chk("R5 narrow 0x7C ordinary", {8'd0, v}, 16'h003D);
        spi_read(1, 7'h22, f, d, t);
        chk("R5 page kept", {8'd0, d}, {8'd0, mem_b[8'hA2]});

        // R4: wide page word, page = {hi, lo[7]}
        page_wide(8'h80, 8'h00);
        pg_a = 9'h001;
        spi_read(0, 7'h05, f, d, t);
        chk("R4 wide page lo msb", {8'd0, d}, {8'd0, mem_a[{pg_a[0], 7'h05}]});
        peek(0, {pg_a[0], 7'h7C}, v);
        chk("R4 page write leaves rf", {8'd0, v}, {8'd0, mem_a[{pg_a[0], 7'h7C}]});
        page_wide(8'h7F, 8'h01);
        pg_a = 9'h002;
        spi_read(0, 7'h05, f, d, t);
        chk("R4 wide page low bits dropped", {8'd0, d}, {8'd0, mem_a[{pg_a[0], 7'h05}]});
        for (int k = 0; k < 4; k++) begin
            logic [6:0] off;
            off = 7'(k * 29 + 3);
            spi_write(0, off, 8'(k + 8'h90));
            mem_a[{pg_a[0], off}] = 8'(k + 8'h90);
            peek(0, {pg_a[0], off}, v);
            chk("R3 wide write", {8'd0, v}, {8'd0, mem_a[{pg_a[0], off}]});
        end

        // R8: only the low half of a wide page word is sent
        cs_set(0, 1'b0);
        xfer(0, 8'h7C, 8, f);
        xfer(0, 8'h80, 8, f);
        cs_set(0, 1'b1);
        spi_read(0, 7'h06, f, d, t);
        chk("R8 partial page word", {8'd0, d}, {8'd0, mem_a[8'h06]});
        // R8: data byte cut after four bits
        cs_set(0, 1'b0);
        xfer(0, 8'h20, 8, f);
        xfer(0, 8'hEE, 4, f);
        cs_set(0, 1'b1);
        peek(0, 8'h20, v);
        chk("R8 partial data byte", {8'd0, v}, {8'd0, mem_a[8'h20]});
        // R8: narrow page byte cut after five bits, counter restarts
        cs_set(1, 1'b0);
        xfer(1, 8'h7F, 8, f);
        xfer(1, 8'h00, 5, f);
        cs_set(1, 1'b1);
        spi_read(1, 7'h22, f, d, t);
        chk("R8 partial page byte", {8'd0, d}, {8'd0, mem_b[8'hA2]});

        // R9: extra bytes after a write are ignored
        cs_set(0, 1'b0);
        xfer(0, 8'h30, 8, f);
        xfer(0, 8'h11, 8, f);
        xfer(0, 8'h22, 8, f);
        xfer(0, 8'h33, 8, f);
        cs_set(0, 1'b1);
        mem_a[8'h30] = 8'h11;
        peek(0, 8'h30, v);
        chk("R9 first data byte kept", {8'd0, v}, 16'h0011);
        peek(0, 8'h31, v);
        chk("R9 neighbour untouched", {8'd0, v}, {8'd0, mem_a[8'h31]});
        spi_read(0, 7'h30, f, d, t);
        chk("R9 read back", {8'd0, d}, 16'h0011);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule